// File: doc/BRIEF.md
# Nibble-Wide BCD Calendar Clock Register File

This block is a calendar clock held as sixteen 4-bit registers, all reached through one 8-bit I/O port. The low address byte selects the port. Address bits 11..8 pick one of the sixteen nibbles, so software using indexed I/O puts the register index in the upper address byte. Address bits 15..12 are ignored.

Each time field is kept as two separate BCD nibbles, one for units and one for tens. The seconds, minutes, hours, day, month and two-digit year count up with carries. A weekday counter advances on every day rollover. A sub-second prescaler divides the `tick_in` pulses down to one advance per second. Three control nibbles hold a hold bit for consistent reads, a stop bit, a prescaler clear bit and the 12/24-hour mode bit.

A system reset input blocks register access while it is high, the way a chip select tied to the reset line would. Time keeps running during that window. A separate power-on reset sets the initial contents.

Top module: `bcd_clock_regfile`

## Requirements
- R1: An access reaches the block only when `io_addr[7:0]` equals `PORT_ADDR` (default 8'h45). `io_addr[11:8]` selects the register and `io_addr[15:12]` has no effect. A read of any other port returns 8'h00, and a write to any other port changes nothing.
- R2: Register index order: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day units, 7 day tens, 8 month units, 9 month tens, 10 year units, 11 year tens, 12 weekday, 13 control D, 14 control E, 15 control F. After power-on reset the day units and month units read 1, control F reads 4 (24-hour mode), and every other register reads 0.
- R3: A write stores only data bits 3..0. A read returns the nibble on bits 3..0 and zero on bits 7..4.
- R4: While `sys_reset` is high, reads return 8'h00 and writes are ignored, but time keeps advancing.
- R5: The block advances the time once every `TICKS_PER_SEC` cycles in which `tick_in` is high. Seconds and minutes count 00..59 in BCD. A units nibble wraps from 9 to 0 and increments its tens nibble, and a wrap of 59 carries into the next field.
- R6: When control F bit 2 is 1 (24-hour mode), hours count 00..23, the hours-tens nibble holds only the tens digit, and 23 wraps to 00 with a carry into the day.
- R7: When control F bit 2 is 0 (12-hour mode), hours count 1..12. The tens digit sits in bits 1..0 of the hours-tens nibble and bit 2 is the PM flag. The flag toggles on the step from 11 to 12, the step from 12 goes to 01, and the step from 11 PM to 12 AM carries into the day.
- R8: A day carry wraps the day to 01 after day 31 for months 1, 3, 5, 7, 8, 10 and 12, after day 30 for months 4, 6, 9 and 11, and after day 28 for February, or day 29 when the BCD year is divisible by 4. A month wrap goes from 12 to 01 and increments the year, and the year wraps from 99 to 00. The weekday counts 0..6 and wraps to 0 on each day carry.
- R9: While control D bit 0 (hold) is 1, the time registers do not advance. Seconds that fall due while holding are remembered, and at most one is applied on the cycle after hold is cleared.
- R10: Control F bit 1 (stop) freezes the prescaler so that no seconds fall due. Control F bit 0 clears the prescaler and keeps it at zero while set.
- R11: When a write and a second advance land in the same cycle, the advance is applied first, including its carries, and the written value then replaces the one addressed nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of all registers |
| sys_reset | input | 1 | High: register access inhibited |
| tick_in | input | 1 | Sub-second tick, one cycle per pulse |
| io_addr | input | 16 | I/O address: port in [7:0], register index in [11:8] |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data, low nibble stored |
| io_rdata | output | 8 | Read data, combinational from the selected nibble |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a software write and a second advance. The bench sets seconds to 59, feeds all but the last sub-tick, and then raises the final `tick_in` in the same cycle as a write to the seconds-units nibble. The check passes only if the written nibble holds the new value while the seconds tens and minutes show the carry from that advance.

The second pair is a hold release and a backlog of seconds. Several seconds fall due while hold is set, and after release the seconds must move by exactly one.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    typedef logic [3:0] nib_t;

    localparam int NREG = 16;

    typedef logic [NREG-1:0][3:0] regfile_t;

    localparam logic [3:0] IX_SEC_U = 4'd0;
    localparam logic [3:0] IX_SEC_T = 4'd1;
    localparam logic [3:0] IX_MIN_U = 4'd2;
    localparam logic [3:0] IX_MIN_T = 4'd3;
    localparam logic [3:0] IX_HR_U  = 4'd4;
    localparam logic [3:0] IX_HR_T  = 4'd5;
    localparam logic [3:0] IX_DAY_U = 4'd6;
    localparam logic [3:0] IX_DAY_T = 4'd7;
    localparam logic [3:0] IX_MON_U = 4'd8;
    localparam logic [3:0] IX_MON_T = 4'd9;
    localparam logic [3:0] IX_YR_U  = 4'd10;
    localparam logic [3:0] IX_YR_T  = 4'd11;
    localparam logic [3:0] IX_WDAY  = 4'd12;
    localparam logic [3:0] IX_CTL_D = 4'd13;
    localparam logic [3:0] IX_CTL_E = 4'd14;
    localparam logic [3:0] IX_CTL_F = 4'd15;

    // control bit positions
    localparam int D_HOLD_BIT  = 0;
    localparam int F_CLR_BIT   = 0;
    localparam int F_STOP_BIT  = 1;
    localparam int F_24H_BIT   = 2;
    // PM flag inside the hours-tens nibble
    localparam int HR_PM_BIT   = 2;

    // days in the current month, from BCD month and BCD year
    function automatic logic [4:0] month_days(nib_t mon_t, nib_t mon_u, nib_t yr_t, nib_t yr_u);
        int mon;
        int yr;
        logic [4:0] days;
        mon = int'(mon_t) * 10 + int'(mon_u);
        yr  = int'(yr_t) * 10 + int'(yr_u);
        case (mon)
            2:             days = ((yr % 4) == 0) ? 5'd29 : 5'd28;
            4, 6, 9, 11:   days = 5'd30;
            default:       days = 5'd31;
        endcase
        return days;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 4,
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             tick,
    input  logic             clr,
    input  logic             stop,
    output logic [CNT_W-1:0] cnt_d,
    output logic             sec_pulse
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    always_comb begin
        cnt_d     = cnt_q;
        sec_pulse = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && !stop) begin
            if (cnt_q == LAST) begin
                cnt_d     = '0;
                sec_pulse = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_port_decode.sv
module rtc_port_decode #(
    parameter logic [7:0] PORT_ADDR = 8'h45
) (
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic        inhibit,
    output logic [3:0]  idx,
    output logic        rd_en,
    output logic        wr_en
);

    logic hit;

    always_comb begin
        hit   = (io_addr[7:0] == PORT_ADDR) && !inhibit;
        idx   = io_addr[11:8];
        rd_en = hit && io_rd;
        wr_en = hit && io_wr;
    end

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import bcd_rtc_pkg::*;
(
    input  regfile_t cur,
    input  logic     mode24,
    output regfile_t nxt
);

    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic [1:0] hr_tens, hr_tens_n;
    logic       pm, pm_n;
    nib_t       hr_u_n;
    logic [4:0] dim;
    logic [4:0] day_val;

    always_comb begin
        nxt   = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        // seconds
        if (cur[IX_SEC_U] >= 4'd9) begin
            nxt[IX_SEC_U] = 4'd0;
            if (cur[IX_SEC_T] >= 4'd5) begin
                nxt[IX_SEC_T] = 4'd0;
                c_min = 1'b1;
            end else begin
                nxt[IX_SEC_T] = cur[IX_SEC_T] + 4'd1;
            end
        end else begin
            nxt[IX_SEC_U] = cur[IX_SEC_U] + 4'd1;
        end

        // minutes
        if (c_min) begin
            if (cur[IX_MIN_U] >= 4'd9) begin
                nxt[IX_MIN_U] = 4'd0;
                if (cur[IX_MIN_T] >= 4'd5) begin
                    nxt[IX_MIN_T] = 4'd0;
                    c_hr = 1'b1;
                end else begin
                    nxt[IX_MIN_T] = cur[IX_MIN_T] + 4'd1;
                end
            end else begin
                nxt[IX_MIN_U] = cur[IX_MIN_U] + 4'd1;
            end
        end

        // hours
        hr_tens   = cur[IX_HR_T][1:0];
        pm        = cur[IX_HR_T][HR_PM_BIT];
        hr_tens_n = hr_tens;
        pm_n      = pm;
        hr_u_n    = cur[IX_HR_U];
        if (mode24) begin
            pm_n = 1'b0;
            if (hr_tens == 2'd2 && cur[IX_HR_U] >= 4'd3) begin
                hr_u_n    = 4'd0;
                hr_tens_n = 2'd0;
                c_day     = c_hr;
            end else if (cur[IX_HR_U] >= 4'd9) begin
                hr_u_n    = 4'd0;
                hr_tens_n = hr_tens + 2'd1;
            end else begin
                hr_u_n = cur[IX_HR_U] + 4'd1;
            end
        end else begin
            if (hr_tens == 2'd1 && cur[IX_HR_U] == 4'd2) begin
                hr_u_n    = 4'd1;
                hr_tens_n = 2'd0;
            end else if (hr_tens == 2'd1 && cur[IX_HR_U] == 4'd1) begin
                hr_u_n    = 4'd2;
                pm_n      = ~pm;
                c_day     = c_hr && pm;
            end else if (cur[IX_HR_U] >= 4'd9) begin
                hr_u_n    = 4'd0;
                hr_tens_n = 2'd1;
            end else begin
                hr_u_n = cur[IX_HR_U] + 4'd1;
            end
        end
        if (c_hr) begin
            nxt[IX_HR_U] = hr_u_n;
            nxt[IX_HR_T] = {1'b0, pm_n, hr_tens_n};
        end

        // day and weekday
        dim     = month_days(cur[IX_MON_T], cur[IX_MON_U], cur[IX_YR_T], cur[IX_YR_U]);
        day_val = 5'(cur[IX_DAY_T] * 4'd10 + cur[IX_DAY_U]);
        if (c_day) begin
            if (day_val >= dim) begin
                nxt[IX_DAY_U] = 4'd1;
                nxt[IX_DAY_T] = 4'd0;
                c_mon = 1'b1;
            end else if (cur[IX_DAY_U] >= 4'd9) begin
                nxt[IX_DAY_U] = 4'd0;
                nxt[IX_DAY_T] = cur[IX_DAY_T] + 4'd1;
            end else begin
                nxt[IX_DAY_U] = cur[IX_DAY_U] + 4'd1;
            end
            nxt[IX_WDAY] = (cur[IX_WDAY] >= 4'd6) ? 4'd0 : cur[IX_WDAY] + 4'd1;
        end

        // month
        if (c_mon) begin
            if (cur[IX_MON_T] == 4'd1 && cur[IX_MON_U] >= 4'd2) begin
                nxt[IX_MON_U] = 4'd1;
                nxt[IX_MON_T] = 4'd0;
                c_yr = 1'b1;
            end else if (cur[IX_MON_U] >= 4'd9) begin
                nxt[IX_MON_U] = 4'd0;
                nxt[IX_MON_T] = 4'd1;
            end else begin
                nxt[IX_MON_U] = cur[IX_MON_U] + 4'd1;
            end
        end

        // year
        if (c_yr) begin
            if (cur[IX_YR_U] >= 4'd9) begin
                nxt[IX_YR_U] = 4'd0;
                nxt[IX_YR_T] = (cur[IX_YR_T] >= 4'd9) ? 4'd0 : cur[IX_YR_T] + 4'd1;
            end else begin
                nxt[IX_YR_U] = cur[IX_YR_U] + 4'd1;
            end
        end
    end

endmodule

// File: rtl/bcd_clock_regfile.sv
module bcd_clock_regfile
    import bcd_rtc_pkg::*;
#(
    parameter int         TICKS_PER_SEC = 4,
    parameter logic [7:0] PORT_ADDR     = 8'h45
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_reset,
    input  logic        tick_in,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata
);

    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

    typedef struct packed {
        regfile_t         regs;
        logic [CNT_W-1:0] cnt;
        logic             pending;
    } state_t;

    state_t st_d, st_q;

    logic [3:0]       idx;
    logic             rd_en, wr_en;
    logic [CNT_W-1:0] cnt_next;
    logic             sec_pulse;
    logic             hold, stop_bit, clr_bit, mode24;
    logic             sec_apply;
    regfile_t         regs_q, adv_regs;
    logic [CNT_W-1:0] cnt_q;

    assign regs_q   = st_q.regs;
    assign cnt_q    = st_q.cnt;
    assign hold     = st_q.regs[IX_CTL_D][D_HOLD_BIT];
    assign stop_bit = st_q.regs[IX_CTL_F][F_STOP_BIT];
    assign clr_bit  = st_q.regs[IX_CTL_F][F_CLR_BIT];
    assign mode24   = st_q.regs[IX_CTL_F][F_24H_BIT];

    rtc_port_decode #(.PORT_ADDR(PORT_ADDR)) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .inhibit (sys_reset),
        .idx     (idx),
        .rd_en   (rd_en),
        .wr_en   (wr_en)
    );

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .cnt_q     (st_q.cnt),
        .tick      (tick_in),
        .clr       (clr_bit),
        .stop      (stop_bit),
        .cnt_d     (cnt_next),
        .sec_pulse (sec_pulse)
    );

    rtc_advance u_adv (
        .cur    (st_q.regs),
        .mode24 (mode24),
        .nxt    (adv_regs)
    );

    assign sec_apply = !hold && (sec_pulse || st_q.pending);

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_next;
        if (hold && sec_pulse) begin
            st_d.pending = 1'b1;
        end else if (sec_apply) begin
            st_d.pending = 1'b0;
        end
        if (sec_apply) begin
            st_d.regs = adv_regs;
        end
        if (wr_en) begin
            st_d.regs[idx] = io_wdata[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                   <= '0;
            st_q.regs[IX_DAY_U]    <= 4'd1;
            st_q.regs[IX_MON_U]    <= 4'd1;
            st_q.regs[IX_CTL_F]    <= 4'b0100;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = rd_en ? {4'h0, st_q.regs[idx]} : 8'h00;

endmodule

// File: rtl/bcd_clock_regfile_chk.sv
module bcd_clock_regfile_chk
    import bcd_rtc_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_reset,
    input logic [7:0]       io_rdata,
    input logic             wr_en,
    input logic             sec_apply,
    input logic             hold,
    input logic             stop_bit,
    input logic             clr_bit,
    input regfile_t         regs_q,
    input logic [CNT_W-1:0] cnt_q
);

    assert_rdata_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[7:4] == 4'h0);

    assert_inhibit_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |-> io_rdata == 8'h00);

    assert_inhibit_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset && !sec_apply) |=> $stable(regs_q));

    assert_units_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_apply && !wr_en && regs_q[IX_SEC_U] <= 4'd9) |=> regs_q[IX_SEC_U] <= 4'd9);

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en) |=> $stable(regs_q[12:0]));

    assert_stop_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_bit && !clr_bit) |=> $stable(cnt_q));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit |=> cnt_q == '0);

endmodule

bind bcd_clock_regfile bcd_clock_regfile_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_reset (sys_reset),
    .io_rdata  (io_rdata),
    .wr_en     (wr_en),
    .sec_apply (sec_apply),
    .hold      (hold),
    .stop_bit  (stop_bit),
    .clr_bit   (clr_bit),
    .regs_q    (regs_q),
    .cnt_q     (cnt_q)
);

// File: tb/bcd_clock_regfile_bench.sv
module bcd_clock_regfile_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         TPS        = 4;
    localparam logic [7:0] PORT       = 8'h45;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_reset = 1'b0;
    logic        tick_in = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int checks = 0;
    int errors = 0;
    logic [3:0] junk = 4'h3;

    bcd_clock_regfile #(.TICKS_PER_SEC(TPS), .PORT_ADDR(PORT)) u_bcd_clock_regfile (
        .clk, .rst_n, .sys_reset, .tick_in, .io_addr, .io_rd, .io_wr, .io_wdata, .io_rdata
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic rd_raw(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        #1 v = io_rdata;
        io_rd   = 1'b0;
    endtask

    task automatic wr_raw(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] d);
        junk = junk + 4'd5;
        wr_raw({junk, ix, PORT}, d);
    endtask

    task automatic expect_reg(input string req, input logic [3:0] ix, input logic [3:0] exp);
        logic [7:0] v;
        junk = junk + 4'd7;
        rd_raw({junk, ix, PORT}, v);
        check(req, $sformatf("reg %0d", ix), v, {4'h0, exp});
    endtask

    task automatic subtick();
        @(negedge clk) tick_in = 1'b1;
        @(negedge clk) tick_in = 1'b0;
    endtask

    task automatic one_second();
        repeat (TPS) subtick();
    endtask

    // clear prescaler and choose hours mode (F: bit0 clear, bit1 stop, bit2 24h)
    task automatic sync_presc(input logic m24);
        wr(4'd15, {5'b0, m24, 2'b01});
        wr(4'd15, {5'b0, m24, 2'b00});
    endtask

    task automatic set_hms(input logic [3:0] ht, hu, mt, mu, st, su);
        wr(4'd5, {4'h0, ht}); wr(4'd4, {4'h0, hu});
        wr(4'd3, {4'h0, mt}); wr(4'd2, {4'h0, mu});
        wr(4'd1, {4'h0, st}); wr(4'd0, {4'h0, su});
    endtask

    task automatic set_date(input logic [3:0] dt, du, nt, nu, yt, yu);
        wr(4'd7, {4'h0, dt}); wr(4'd6, {4'h0, du});
        wr(4'd9, {4'h0, nt}); wr(4'd8, {4'h0, nu});
        wr(4'd11, {4'h0, yt}); wr(4'd10, {4'h0, yu});
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 16; i++) begin
            logic [3:0] e;
            e = (i == 6 || i == 8) ? 4'd1 : (i == 15) ? 4'd4 : 4'd0;
            expect_reg("R2", 4'(i), e);
        end
    endtask

    task automatic t_decode();
        logic [7:0] v;
        wr_raw({4'hA, 4'd14, PORT}, 8'h05);
        rd_raw({4'h6, 4'd14, PORT}, v);
        check("R1", "upper bits ignored", v, 8'h05);
        wr_raw({4'h0, 4'd14, 8'h46}, 8'h09);
        expect_reg("R1", 4'd14, 4'd5);
        rd_raw({4'h0, 4'd14, 8'h44}, v);
        check("R1", "other port read", v, 8'h00);
    endtask

    task automatic t_nibble();
        wr(4'd14, 8'hF7);
        expect_reg("R3", 4'd14, 4'd7);
    endtask

    task automatic t_24h_rollover();
        sync_presc(1'b1);
        set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd3);
        wr(4'd12, 8'h06);
        set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd8);
        repeat (TPS - 1) subtick();
        expect_reg("R5", 4'd0, 4'd8);
        subtick();
        expect_reg("R5", 4'd0, 4'd9);
        one_second();
        expect_reg("R5", 4'd0, 4'd0); expect_reg("R5", 4'd1, 4'd0);
        expect_reg("R5", 4'd2, 4'd0); expect_reg("R5", 4'd3, 4'd0);
        expect_reg("R6", 4'd4, 4'd0); expect_reg("R6", 4'd5, 4'd0);
        expect_reg("R8", 4'd7, 4'd0); expect_reg("R8", 4'd6, 4'd1);
        expect_reg("R8", 4'd9, 4'd0); expect_reg("R8", 4'd8, 4'd3);
        expect_reg("R8", 4'd12, 4'd0);
    endtask

    task automatic t_calendar();
        sync_presc(1'b1);
        set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd4);
        set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R8", 4'd7, 4'd2); expect_reg("R8", 4'd6, 4'd9);
        expect_reg("R8", 4'd8, 4'd2);
        set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R8", 4'd6, 4'd1); expect_reg("R8", 4'd8, 4'd3);
        set_date(4'd3, 4'd0, 4'd0, 4'd4, 4'd2, 4'd4);
        set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R8", 4'd7, 4'd0); expect_reg("R8", 4'd8, 4'd5);
        set_date(4'd3, 4'd1, 4'd1, 4'd2, 4'd9, 4'd9);
        set_hms(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R8", 4'd6, 4'd1); expect_reg("R8", 4'd9, 4'd0);
        expect_reg("R8", 4'd8, 4'd1); expect_reg("R8", 4'd11, 4'd0);
        expect_reg("R8", 4'd10, 4'd0);
    endtask

    task automatic t_12h();
        sync_presc(1'b0);
        set_hms(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R7", 4'd5, 4'd5); expect_reg("R7", 4'd4, 4'd2);
        set_date(4'd1, 4'd0, 4'd0, 4'd3, 4'd2, 4'd5);
        set_hms(4'd5, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R7", 4'd5, 4'd1); expect_reg("R7", 4'd4, 4'd2);
        expect_reg("R7", 4'd6, 4'd1);
        set_hms(4'd1, 4'd2, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R7", 4'd5, 4'd0); expect_reg("R7", 4'd4, 4'd1);
        set_hms(4'd4, 4'd9, 4'd5, 4'd9, 4'd5, 4'd9);
        one_second();
        expect_reg("R7", 4'd5, 4'd5); expect_reg("R7", 4'd4, 4'd0);
    endtask

    task automatic t_hold();
        sync_presc(1'b1);
        set_hms(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0);
        wr(4'd13, 8'h01);
        repeat (3) one_second();
        expect_reg("R9", 4'd0, 4'd0);
        wr(4'd13, 8'h00);
        repeat (3) @(negedge clk);
        expect_reg("R9", 4'd0, 4'd1);
    endtask

    task automatic t_stop_clear();
        sync_presc(1'b1);
        set_hms(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0);
        wr(4'd15, 8'h06);
        repeat (2) one_second();
        expect_reg("R10", 4'd0, 4'd0);
        wr(4'd15, 8'h04);
        one_second();
        expect_reg("R10", 4'd0, 4'd1);
        repeat (2) subtick();
        sync_presc(1'b1);
        repeat (TPS - 1) subtick();
        expect_reg("R10", 4'd0, 4'd1);
        subtick();
        expect_reg("R10", 4'd0, 4'd2);
    endtask

    task automatic t_inhibit();
        logic [7:0] v;
        sync_presc(1'b1);
        wr(4'd0, 8'h02);
        @(negedge clk) sys_reset = 1'b1;
        rd_raw({4'h0, 4'd0, PORT}, v);
        check("R4", "read while inhibited", v, 8'h00);
        wr(4'd0, 8'h07);
        one_second();
        @(negedge clk) sys_reset = 1'b0;
        expect_reg("R4", 4'd0, 4'd3);
    endtask

    task automatic t_collision();
        sync_presc(1'b1);
        set_hms(4'd0, 4'd0, 4'd0, 4'd0, 4'd5, 4'd9);
        repeat (TPS - 1) subtick();
        @(negedge clk);
        tick_in  = 1'b1;
        io_addr  = {4'h0, 4'd0, PORT};
        io_wdata = 8'h03;
        io_wr    = 1'b1;
        @(negedge clk);
        tick_in  = 1'b0;
        io_wr    = 1'b0;
        expect_reg("R11", 4'd0, 4'd3);
        expect_reg("R11", 4'd1, 4'd0);
        expect_reg("R11", 4'd2, 4'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_decode();
        t_nibble();
        t_24h_rollover();
        t_calendar();
        t_12h();
        t_hold();
        t_stop_clear();
        t_inhibit();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule